// File: doc/BRIEF.md
# Barrel-Scheduled Peripheral Processor Sequencer

This block lets ten small peripheral processors take turns on one shared execution slot. A slot counter visits processor 0, 1, and so on up to 9, then wraps back to 0. In each cycle the block runs one instruction cycle for the processor that owns the slot. Each processor keeps its own program counter, its own central-memory address register and its own private memory of 12-bit words. A small command port stands in for the full instruction set. Whatever command is on the port in a cycle belongs to the processor whose slot it is.

A central-memory access is issued in a processor's slot and takes one full rotation. For a read, the returned 60-bit word is captured when that processor's slot comes round again. It is then split into five 12-bit words in that processor's memory. For a write, five consecutive 12-bit words are packed into one 60-bit word and sent out together with the processor's address register. While a processor waits on an access, its slots do nothing else.

The private memory depth is set by a parameter. The default keeps elaboration small, and setting `AddrW` to 12 gives the full 4096-word memory.

Top module: `pp_barrel`

## Requirements
- R1: During and just after reset, `slotId` is 0, every processor's program counter is 0, no processor is busy, and `cmReq` and `rdValid` are low.
- R2: `slotId` steps by one every clock, from 0 up to 9, and wraps from 9 to 0.
- R3: Command code 1 (put) writes `cmdData` at `cmdAddr` in the private memory of the slot's processor only. The memories of the other processors are not changed.
- R4: Command code 2 (get) raises `rdValid` in the next cycle, with `rdData` equal to the word at `cmdAddr` in the slot's processor memory.
- R5: Command code 4 (central read) raises `cmReq` with `cmWe` low in the next cycle and marks the processor busy. Every command presented in that processor's slots is ignored until its access completes, including the slot in which it completes.
- R6: A central read completes in the processor's next slot, ten cycles after issue. In that slot `cmRdata` is captured and unpacked: bits 59:48 go to the destination address, and bits 47:36, 35:24, 23:12 and 11:0 go to the next four addresses in turn. Addresses wrap modulo the memory depth.
- R7: Command code 5 (central write) raises `cmReq` and `cmWe` in the next cycle. It drives `cmWdata` with the five words starting at `cmdAddr`, the first word in bits 59:48 and addresses wrapping. The processor is busy until its next slot.
- R8: `slotPc` shows the program counter of the slot's processor. The counter rises by one, modulo 4096, for each accepted command with code 1 to 5. It does not change for code 0, codes 6 and 7, ignored commands, or the completing slot.
- R9: Command code 3 (load address) sets the processor's address register from `cmdCmAddr`. Later central accesses of that processor drive `cmAddr` with this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdOp | input | 3 | Command for the slot's processor (0 idle, 1 put, 2 get, 3 load address, 4 central read, 5 central write) |
| cmdAddr | input | 8 | Private-memory address, or first of five addresses |
| cmdData | input | 12 | Data for a put |
| cmdCmAddr | input | 18 | Value for the address register |
| cmRdata | input | 60 | Central read data, valid in the requester's return slot |
| slotId | output | 4 | Processor owning the current slot |
| slotBusy | output | 1 | Slot's processor waits on a central access |
| slotPc | output | 12 | Program counter of the slot's processor |
| rdValid | output | 1 | Get result valid |
| rdData | output | 12 | Get result |
| cmReq | output | 1 | Central access request pulse |
| cmWe | output | 1 | Request is a write |
| cmAddr | output | 18 | Central address of the request |
| cmWdata | output | 60 | Packed central write word |

## Verification
The assertions rely on the central memory returning the word on `cmRdata` exactly in the requester's return slot, and on `cmdOp` always being meant for the processor in the current slot. The stimulus meets both conditions. The bench drives `cmRdata` every cycle from a pattern of the address the current slot's processor last requested. It also fills every private memory word before any get or central write reads it, so no packed or returned value depends on uninitialised storage.

// File: rtl/pp_barrel_pkg.sv
package pp_barrel_pkg;

  localparam int WordW = 12;
  localparam int Parts = 5;
  localparam int CmW   = WordW * Parts;

  typedef enum logic [2:0] {
    OpIdle    = 3'd0,
    OpPut     = 3'd1,
    OpGet     = 3'd2,
    OpLoadA   = 3'd3,
    OpCmRead  = 3'd4,
    OpCmWrite = 3'd5
  } ppOpE;

  // strobes from control to datapath for the current slot
  typedef struct packed {
    logic putWord;
    logic getWord;
    logic cmIssue;
    logic cmIsWrite;
    logic unpack;
  } ppStrobeT;

endpackage

// File: rtl/pp_barrel_slot.sv
module pp_barrel_slot #(
  parameter int NumPp = 10,
  localparam int SlotW = $clog2(NumPp)
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [SlotW-1:0] slotQ
);

  localparam logic [SlotW-1:0] LastSlot = SlotW'(NumPp - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 slotQ <= '0;
    else if (slotQ == LastSlot) slotQ <= '0;
    else                       slotQ <= slotQ + SlotW'(1);
  end

  // R2: rotation wraps after the last processor
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (slotQ == LastSlot) |=> (slotQ == '0));

  // R2: otherwise steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (slotQ != LastSlot) |=> (slotQ == $past(slotQ) + SlotW'(1)));

endmodule

// File: rtl/pp_barrel_ctrl.sv
module pp_barrel_ctrl
  import pp_barrel_pkg::*;
#(
  parameter int NumPp   = 10,
  parameter int AddrW   = 8,
  parameter int CmAddrW = 18,
  parameter int PcW     = 12,
  localparam int SlotW  = $clog2(NumPp)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SlotW-1:0]   slotQ,
  input  logic [2:0]         cmdOp,
  input  logic [AddrW-1:0]   cmdAddr,
  input  logic [CmAddrW-1:0] cmdCmAddr,
  output ppStrobeT           stb,
  output logic               slotBusy,
  output logic [PcW-1:0]     slotPc,
  output logic [CmAddrW-1:0] issueAddr,
  output logic [AddrW-1:0]   unpackBase
);

  logic [NumPp-1:0]   busyQ;
  logic [NumPp-1:0]   isWrQ;
  logic [PcW-1:0]     pcQ   [NumPp];
  logic [CmAddrW-1:0] aRegQ [NumPp];
  logic [AddrW-1:0]   destQ [NumPp];

  logic accept;
  logic loadA;
  logic curBusy;

  assign curBusy = busyQ[slotQ];

  always_comb begin
    stb    = '0;
    accept = 1'b0;
    loadA  = 1'b0;
    if (curBusy) begin
      // return slot of an outstanding access: consumed by completion
      stb.unpack = !isWrQ[slotQ];
    end else begin
      case (cmdOp)
        OpPut:     begin stb.putWord = 1'b1; accept = 1'b1; end
        OpGet:     begin stb.getWord = 1'b1; accept = 1'b1; end
        OpLoadA:   begin loadA = 1'b1;       accept = 1'b1; end
        OpCmRead:  begin stb.cmIssue = 1'b1; accept = 1'b1; end
        OpCmWrite: begin
          stb.cmIssue   = 1'b1;
          stb.cmIsWrite = 1'b1;
          accept        = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= '0;
      isWrQ <= '0;
      for (int i = 0; i < NumPp; i++) begin
        pcQ[i]   <= '0;
        aRegQ[i] <= '0;
        destQ[i] <= '0;
      end
    end else begin
      if (curBusy)  busyQ[slotQ] <= 1'b0;
      if (accept)   pcQ[slotQ]   <= pcQ[slotQ] + PcW'(1);
      if (loadA)    aRegQ[slotQ] <= cmdCmAddr;
      if (stb.cmIssue) begin
        busyQ[slotQ] <= 1'b1;
        isWrQ[slotQ] <= stb.cmIsWrite;
        destQ[slotQ] <= cmdAddr;
      end
    end
  end

  assign slotBusy   = curBusy;
  assign slotPc     = pcQ[slotQ];
  assign issueAddr  = aRegQ[slotQ];
  assign unpackBase = destQ[slotQ];

  // R5: an issuing processor is marked as waiting
  a_r5_issue_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmIssue |=> busyQ[$past(slotQ)]);

  // R8: a waiting processor's program counter does not move in its slot
  a_r8_pc_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    curBusy |=> (pcQ[$past(slotQ)] == $past(slotPc)));

endmodule

// File: rtl/pp_barrel_dp.sv
module pp_barrel_dp
  import pp_barrel_pkg::*;
#(
  parameter int NumPp   = 10,
  parameter int AddrW   = 8,
  parameter int CmAddrW = 18,
  localparam int SlotW  = $clog2(NumPp),
  localparam int Depth  = 1 << AddrW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SlotW-1:0]   slotQ,
  input  ppStrobeT           stb,
  input  logic [AddrW-1:0]   cmdAddr,
  input  logic [WordW-1:0]   cmdData,
  input  logic [AddrW-1:0]   unpackBase,
  input  logic [CmAddrW-1:0] issueAddr,
  input  logic [CmW-1:0]     cmRdata,
  output logic               rdValid,
  output logic [WordW-1:0]   rdData,
  output logic               cmReq,
  output logic               cmWe,
  output logic [CmAddrW-1:0] cmAddr,
  output logic [CmW-1:0]     cmWdata
);

  logic [WordW-1:0] memQ [NumPp][Depth];

  logic [AddrW-1:0] packAddr [Parts];
  logic [AddrW-1:0] unpAddr  [Parts];
  logic [CmW-1:0]   packWord;

  for (genvar g = 0; g < Parts; g++) begin : gPart
    assign packAddr[g] = cmdAddr + AddrW'(g);
    assign unpAddr[g]  = unpackBase + AddrW'(g);
    assign packWord[CmW-1-g*WordW -: WordW] = memQ[slotQ][packAddr[g]];
  end

  // private memories: one processor touched per cycle
  always_ff @(posedge clk) begin
    if (stb.putWord) memQ[slotQ][cmdAddr] <= cmdData;
    if (stb.unpack) begin
      for (int i = 0; i < Parts; i++)
        memQ[slotQ][unpAddr[i]] <= cmRdata[CmW-1-i*WordW -: WordW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      cmReq   <= 1'b0;
      cmWe    <= 1'b0;
      cmAddr  <= '0;
      cmWdata <= '0;
    end else begin
      rdValid <= stb.getWord;
      if (stb.getWord) rdData <= memQ[slotQ][cmdAddr];
      cmReq <= stb.cmIssue;
      cmWe  <= stb.cmIssue & stb.cmIsWrite;
      if (stb.cmIssue) cmAddr <= issueAddr;
      if (stb.cmIssue & stb.cmIsWrite) cmWdata <= packWord;
    end
  end

  // R7: a write strobe never appears without a request
  a_r7_we_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    cmWe |-> cmReq);

  // R5: a completion slot never also writes a command word
  a_r5_no_put_on_return: assert property (@(posedge clk) disable iff (!rstN)
    stb.unpack |-> !stb.putWord);

endmodule

// File: rtl/pp_barrel.sv
module pp_barrel
  import pp_barrel_pkg::*;
#(
  parameter int NumPp   = 10,
  parameter int AddrW   = 8,
  parameter int CmAddrW = 18,
  parameter int PcW     = 12,
  localparam int SlotW  = $clog2(NumPp)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         cmdOp,
  input  logic [AddrW-1:0]   cmdAddr,
  input  logic [WordW-1:0]   cmdData,
  input  logic [CmAddrW-1:0] cmdCmAddr,
  input  logic [CmW-1:0]     cmRdata,
  output logic [SlotW-1:0]   slotId,
  output logic               slotBusy,
  output logic [PcW-1:0]     slotPc,
  output logic               rdValid,
  output logic [WordW-1:0]   rdData,
  output logic               cmReq,
  output logic               cmWe,
  output logic [CmAddrW-1:0] cmAddr,
  output logic [CmW-1:0]     cmWdata
);

  logic [SlotW-1:0]   slotQ;
  ppStrobeT           stb;
  logic [CmAddrW-1:0] issueAddr;
  logic [AddrW-1:0]   unpackBase;

  pp_barrel_slot #(.NumPp(NumPp)) uSlot (
    .clk   (clk),
    .rstN  (rstN),
    .slotQ (slotQ)
  );

  pp_barrel_ctrl #(
    .NumPp(NumPp), .AddrW(AddrW), .CmAddrW(CmAddrW), .PcW(PcW)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .slotQ      (slotQ),
    .cmdOp      (cmdOp),
    .cmdAddr    (cmdAddr),
    .cmdCmAddr  (cmdCmAddr),
    .stb        (stb),
    .slotBusy   (slotBusy),
    .slotPc     (slotPc),
    .issueAddr  (issueAddr),
    .unpackBase (unpackBase)
  );

  pp_barrel_dp #(
    .NumPp(NumPp), .AddrW(AddrW), .CmAddrW(CmAddrW)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .slotQ      (slotQ),
    .stb        (stb),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .unpackBase (unpackBase),
    .issueAddr  (issueAddr),
    .cmRdata    (cmRdata),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .cmReq      (cmReq),
    .cmWe       (cmWe),
    .cmAddr     (cmAddr),
    .cmWdata    (cmWdata)
  );

  assign slotId = slotQ;

endmodule

// File: tb/pp_barrel_test.sv
`timescale 1ns/1ps
module pp_barrel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [7:0]  cmdAddr = '0;
  logic [11:0] cmdData = '0;
  logic [17:0] cmdCmAddr = '0;
  logic [59:0] cmRdata = '0;
  logic [3:0]  slotId;
  logic        slotBusy;
  logic [11:0] slotPc;
  logic        rdValid;
  logic [11:0] rdData;
  logic        cmReq;
  logic        cmWe;
  logic [17:0] cmAddr;
  logic [59:0] cmWdata;

  always #2.5 clk = ~clk;

  pp_barrel uut (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdCmAddr(cmdCmAddr), .cmRdata(cmRdata),
    .slotId(slotId), .slotBusy(slotBusy), .slotPc(slotPc),
    .rdValid(rdValid), .rdData(rdData), .cmReq(cmReq), .cmWe(cmWe),
    .cmAddr(cmAddr), .cmWdata(cmWdata)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  // behavioural reference state
  int          mSlot = 0;
  bit          mBusy [10];
  bit          mWr [10];
  int          mDest [10];
  int          mPc [10];
  int          mA [10];
  int          mIssued [10];
  int          mMem [10][256];
  bit          eRdV = 0;
  int          eRd = 0;
  bit          eReq = 0;
  bit          eWe = 0;
  int          eAddr = 0;
  logic [59:0] eWdata = '0;

  function automatic logic [59:0] pat(input int a);
    logic [17:0] x;
    x = 18'(a);
    return {6'h2D, x, ~x, x ^ 18'h15555};
  endfunction

  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSlot = 0; eRdV = 0; eReq = 0; eWe = 0;
      for (int p = 0; p < 10; p++) begin
        mBusy[p] = 0; mPc[p] = 0; mA[p] = 0; mWr[p] = 0;
      end
    end else begin
      int p;
      p = mSlot;
      eRdV = 0; eReq = 0; eWe = 0;
      if (mBusy[p]) begin
        if (!mWr[p])
          for (int i = 0; i < 5; i++)
            mMem[p][(mDest[p] + i) % 256] = int'((cmRdata >> (48 - 12*i)) & 60'hFFF);
        mBusy[p] = 0;
      end else begin
        case (cmdOp)
          3'd1: mMem[p][cmdAddr] = int'(cmdData);
          3'd2: begin eRdV = 1; eRd = mMem[p][cmdAddr]; end
          3'd3: mA[p] = int'(cmdCmAddr);
          3'd4: begin
            mBusy[p] = 1; mWr[p] = 0; mDest[p] = int'(cmdAddr);
            eReq = 1; eAddr = mA[p]; mIssued[p] = mA[p];
          end
          3'd5: begin
            mBusy[p] = 1; mWr[p] = 1;
            eReq = 1; eWe = 1; eAddr = mA[p];
            eWdata = '0;
            for (int i = 0; i < 5; i++)
              eWdata = (eWdata << 12) | 60'(mMem[p][(int'(cmdAddr) + i) % 256]);
          end
          default: ;
        endcase
        if (cmdOp >= 3'd1 && cmdOp <= 3'd5) mPc[p] = (mPc[p] + 1) & 12'hFFF;
      end
      mSlot = (p + 1) % 10;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(slotId == 4'(mSlot), "R2 slotId", slotId, mSlot);
    chk(slotPc == 12'(mPc[mSlot]), "R8 slotPc", slotPc, mPc[mSlot]);
    chk(slotBusy == mBusy[mSlot], "R5 slotBusy", slotBusy, mBusy[mSlot]);
    chk(rdValid == eRdV, "R4 rdValid", rdValid, eRdV);
    if (eRdV) chk(rdData == 12'(eRd), "R3,R6 rdData", rdData, eRd);
    chk(cmReq == eReq, "R5 cmReq", cmReq, eReq);
    if (eReq) begin
      chk(cmWe == eWe, "R7 cmWe", cmWe, eWe);
      chk(cmAddr == 18'(eAddr), "R9 cmAddr", cmAddr, eAddr);
    end
    if (eWe) chk(cmWdata == eWdata, "R7 cmWdata", cmWdata, eWdata);
  endtask

  task automatic step(input int op, input int a, input int d, input int cm);
    @(negedge clk);
    compareAll();
    cmdOp     = 3'(op);
    cmdAddr   = 8'(a);
    cmdData   = 12'(d);
    cmdCmAddr = 18'(cm);
    cmRdata   = pat(mIssued[mSlot]);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(slotId == 0, "R1 slotId", slotId, 0);
      chk(slotPc == 0, "R1 slotPc", slotPc, 0);
      chk(slotBusy == 0, "R1 slotBusy", slotBusy, 0);
      chk(cmReq == 0, "R1 cmReq", cmReq, 0);
      chk(rdValid == 0, "R1 rdValid", rdValid, 0);
    end
    rstN = 1'b1;
    // R3: fill every word of every processor with a distinct value
    for (int k = 0; k < 256; k++)
      for (int p = 0; p < 10; p++)
        step(1, k, (p * 256 + k * 7) & 12'hFFF, 0);
    // R4: read back a spread of addresses
    for (int k = 0; k < 30; k++) step(2, k * 9, 0, 0);
    // R9: load address registers, including the largest value
    for (int p = 0; p < 10; p++) step(3, 0, 0, (p == 9) ? 18'h3FFFF : 1000 + p * 7);
    // R5/R6: every processor reads, processor 0 wrapping at the top of memory
    for (int p = 0; p < 10; p++) step(4, (p == 0) ? 253 : p * 10, 0, 0);
    // R5: puts in the return slots must be ignored
    for (int p = 0; p < 10; p++) step(1, (p == 0) ? 253 : p * 10, 12'hABC, 0);
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 10; p++) step(2, (p == 0) ? (253 + k) % 256 : p * 10 + k, 0, 0);
    // R7: packing, processor 3 wrapping
    for (int p = 0; p < 10; p++) step(5, (p == 3) ? 254 : p * 10, 0, 0);
    for (int p = 0; p < 10; p++) step(0, 0, 0, 0);
    // R8: mixed traffic including unused codes 6 and 7
    for (int k = 0; k < 3000; k++)
      step(int'(nextRand() % 8), int'(nextRand() % 256),
           int'(nextRand() % 4096), int'(nextRand() % 262144));
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog got running exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule